// File: doc/BRIEF.md
# Programmable CIC Decimation Filter

This block is a multiplier-free low-pass decimator for 16-bit two's-complement fractional samples. It is built from a cascade of integrators that run at the input sample rate and a cascade of combs that run at the decimated rate. A run-time stage count selects how many of the five integrator/comb pairs are active. A stage that is switched off has its feedback or delay term forced to zero, so data passes through it unchanged. The decimation factor is the programmed rate field plus one, from 1 to 1024.

Each accepted sample is sign-extended into a 66-bit word and shifted left by a growth amount, which fixes where its LSB sits. The maximum possible gain therefore reaches bit 65 and no further. Every stage keeps the same MSB (bit 65). Stage widths are pruned by discarding low-order bits, and the number discarded grows along the chain. The 19 most significant bits of the last comb hold 16 integer bits and 3 fraction bits. These bits go to a symmetric rounder with positive saturation, and its result is registered as the output sample. Everything runs on one clock. The decimated rate is a one-cycle enable, not a derived clock. A bypass mode makes the filter a pure pipeline that passes samples through unchanged.

Samples enter and leave on valid/ready streams. A sample is accepted on a rising edge where `in_valid` and `in_ready` are both high. An output sample is offered with `out_valid` and stays unchanged until a cycle in which `out_ready` is high. While an offered output waits, the block holds `in_ready` low, so back-pressure at the output stalls the input side.

Top module: `cic_decim`

## Requirements
- R1: After reset and until `start` has been sampled high on a rising edge, `in_ready` is low. After that, `in_ready` is high exactly when no output is pending or `out_ready` is high.
- R2: One output is produced on every (effective rate + 1)-th accepted sample. The effective rate is `cfg_rate`, or 0 in bypass. `out_valid` rises on the edge that accepts that sample.
- R3: While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `in_ready` is low. `out_valid` falls after an edge that sees `out_ready` high with no new output produced.
- R4: The effective stage count is `cfg_stages`, with values above 5 treated as 5, and 0 in bypass. Integrator and comb stage k (1..5) are active exactly when k is no greater than the effective count. An inactive stage passes its input through unchanged.
- R5: An accepted sample is placed with its LSB at bit position g of a 66-bit word. Here g is `cfg_growth`, with values above 50 treated as 50, and 50 in bypass. The growth value matching a filter is 50 minus the ceiling of stages × log2(decimation).
- R6: In bypass mode, every accepted sample yields an output. That output equals the sample accepted six accepts earlier, and is 0 for the first six.
- R7: The 19-bit comb result (16 integer bits, 3 fraction bits) is rounded to the nearest integer, with ties rounded away from zero. For a value of +x.5 the result is x+1, and for −x.5 it is −x−1.
- R8: A rounded value that would exceed +32767 is saturated to +32767 (0x7FFF).
- R9: Each output is within 1 LSB of a full-precision CIC with the same structure. In that reference, an output produced on a decimation event is the comb response computed from the integrator-chain output captured on the previous event, and the integrators update on every accepted sample.
- R10: When the stages and rate make the gain an exact power of two and the growth value is correct, a constant input x settles to an output within 1 LSB of x.
- R11: Reset clears all integrator, decimation, comb and output registers, the decimation counter and the started state. During reset `out_valid` is 0, `out_data` is 0 and `in_ready` is 0.
- R12: The decimation counter advances only on accepted samples. Cycles without acceptance do not move the output cadence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Sampled high once to let the block accept samples |
| cfg_stages | input | 3 | Active stage count, 0 to 5 (larger values act as 5) |
| cfg_rate | input | 10 | Decimation factor minus one |
| cfg_growth | input | 6 | LSB position of the shifted input sample |
| cfg_bypass | input | 1 | 1 selects pass-through: stages 0, rate 0, growth 50 |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | 16 | Two's-complement input sample |
| out_valid | output | 1 | Output sample offered |
| out_ready | input | 1 | Consumer takes the offered output |
| out_data | output | 16 | Rounded, saturated output sample |

## Verification
The bench aims at the rounding ties, using DC inputs that land exactly on ±x.5. A rounder that truncated or rounded ties toward zero would be off by one LSB there. It also drives a DC input that lands on +32767.5. A design without saturation would then wrap to −32768. Further cases are stage counts and growth values above their limits, which would misplace or overflow the data if not clamped, and irregular valid/ready patterns. The latter would expose a counter that ticked on stalled cycles, or an output that changed while it was held.

// File: rtl/cic_pkg.sv
package cic_pkg;
  localparam int IN_W     = 16;
  localparam int MAX_N    = 5;
  localparam int STG_W    = 3;
  localparam int RATE_W   = 10;
  localparam int GROW_W   = 6;
  localparam int GROW_MAX = 50;
  localparam int FRAC_W   = 3;
  localparam int ACC_W    = IN_W + GROW_MAX;
  localparam int RND_W    = IN_W + FRAC_W;
  localparam int OUT_LSB  = ACC_W - RND_W;

  // lowest kept bit per stage; all stages share the MSB at ACC_W-1
  localparam int INT_LSB [MAX_N] = '{0, 3, 13, 23, 31};
  localparam int DEC_LSB         = 40;
  localparam int CMB_LSB [MAX_N] = '{40, 44, 45, 46, OUT_LSB};

  typedef logic [ACC_W-1:0] acc_t;

  function automatic acc_t lsb_mask(input int lsb);
    return ~((acc_t'(1) << lsb) - acc_t'(1));
  endfunction
endpackage

// File: rtl/cic_rate_ctrl.sv
module cic_rate_ctrl
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic [RATE_W-1:0] rate_eff,
  output logic              in_ready,
  output logic              adv,
  output logic              ev,
  output logic              out_valid
);
  logic              run_q;
  logic [RATE_W-1:0] cnt_q;

  assign in_ready = run_q && (!out_valid || out_ready);
  assign adv      = in_valid && in_ready;
  assign ev       = adv && (cnt_q >= rate_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      run_q <= run_q | start;
      if (adv) cnt_q <= ev ? '0 : cnt_q + 1'b1;
      if (ev) out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end

  // R1: nothing can be emitted before the block is started
  assert_idle_before_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> !out_valid);

  // R12: stalled cycles leave the cadence counter alone
  assert_cnt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/cic_integ_bank.sv
module cic_integ_bank
  import cic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [MAX_N-1:0] stage_on,
  input  acc_t             din,
  output acc_t             dout
);
  logic [MAX_N:0][ACC_W-1:0] tap;
  assign tap[0] = din;

  for (genvar k = 0; k < MAX_N; k++) begin : g_int
    localparam acc_t KEEP = lsb_mask(INT_LSB[k]);
    acc_t acc_q;
    acc_t fb;
    assign fb = stage_on[k] ? acc_q : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc_q <= '0;
      else if (adv) acc_q <= (fb + tap[k]) & KEEP;
    end
    assign tap[k+1] = acc_q;

    // R4: an inactive integrator only delays (and truncates) its input
    assert_int_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
      adv && !stage_on[k] |=> acc_q == ($past(tap[k]) & KEEP));
  end

  assign dout = tap[MAX_N];
endmodule

// File: rtl/cic_comb_bank.sv
module cic_comb_bank
  import cic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic [MAX_N-1:0] stage_on,
  input  acc_t             din,
  output logic [RND_W-1:0] dout
);
  localparam acc_t DEC_KEEP = lsb_mask(DEC_LSB);

  acc_t dec_q;
  logic [MAX_N:0][ACC_W-1:0] tap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  dec_q <= '0;
    else if (ev) dec_q <= din & DEC_KEEP;
  end
  assign tap[0] = dec_q;

  for (genvar k = 0; k < MAX_N; k++) begin : g_cmb
    localparam acc_t KEEP = lsb_mask(CMB_LSB[k]);
    acc_t cur;
    acc_t dly_q;
    assign cur = tap[k] & KEEP;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  dly_q <= '0;
      else if (ev) dly_q <= cur;
    end
    assign tap[k+1] = (cur - (stage_on[k] ? dly_q : '0)) & KEEP;
  end

  assign dout = tap[MAX_N][ACC_W-1 -: RND_W];

  logic unused_lsbs;
  assign unused_lsbs = ^tap[MAX_N][OUT_LSB-1:0];
endmodule

// File: rtl/cic_round_sat.sv
module cic_round_sat
  import cic_pkg::*;
(
  input  logic [RND_W-1:0] v,
  output logic [IN_W-1:0]  y
);
  localparam logic [FRAC_W-1:0] HALF   = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [IN_W-1:0]   MAXPOS = {1'b0, {(IN_W-1){1'b1}}};

  logic [IN_W-1:0]   ip;
  logic [FRAC_W-1:0] fr;
  logic              up;

  always_comb begin
    ip = v[RND_W-1:FRAC_W];
    fr = v[FRAC_W-1:0];
    // ties go away from zero: up on >= half when positive, > half when negative
    up = v[RND_W-1] ? (fr > HALF) : (fr >= HALF);
    if (up && ip == MAXPOS) y = MAXPOS;
    else                    y = ip + IN_W'(up);
  end
endmodule

// File: rtl/cic_decim.sv
module cic_decim
  import cic_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STG_W-1:0]  cfg_stages,
  input  logic [RATE_W-1:0] cfg_rate,
  input  logic [GROW_W-1:0] cfg_growth,
  input  logic              cfg_bypass,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [IN_W-1:0]   in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IN_W-1:0]   out_data
);
  localparam logic [FRAC_W-1:0] HALF   = FRAC_W'(1) << (FRAC_W - 1);
  localparam logic [IN_W-1:0]   MAXPOS = {1'b0, {(IN_W-1){1'b1}}};

  logic [STG_W-1:0]  n_eff;
  logic [RATE_W-1:0] rate_eff;
  logic [GROW_W-1:0] g_eff;
  logic [MAX_N-1:0]  stage_on;
  acc_t              ext, shifted, integ_out;
  logic [RND_W-1:0]  rnd_in;
  logic [IN_W-1:0]   rounded;
  logic              adv, ev;

  always_comb begin
    if (cfg_bypass) begin
      n_eff    = '0;
      rate_eff = '0;
      g_eff    = GROW_W'(GROW_MAX);
    end else begin
      n_eff    = (cfg_stages > STG_W'(MAX_N)) ? STG_W'(MAX_N) : cfg_stages;
      rate_eff = cfg_rate;
      g_eff    = (cfg_growth > GROW_W'(GROW_MAX)) ? GROW_W'(GROW_MAX) : cfg_growth;
    end
  end

  for (genvar k = 0; k < MAX_N; k++) begin : g_on
    assign stage_on[k] = (int'(n_eff) > k);
  end

  assign ext     = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign shifted = ext << g_eff;

  cic_rate_ctrl u_rate (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .rate_eff(rate_eff), .in_ready(in_ready),
    .adv(adv), .ev(ev), .out_valid(out_valid)
  );

  cic_integ_bank u_int (
    .clk(clk), .rst_n(rst_n), .adv(adv), .stage_on(stage_on),
    .din(shifted), .dout(integ_out)
  );

  cic_comb_bank u_cmb (
    .clk(clk), .rst_n(rst_n), .ev(ev), .stage_on(stage_on),
    .din(integ_out), .dout(rnd_in)
  );

  cic_round_sat u_rnd (.v(rnd_in), .y(rounded));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_data <= '0;
    else if (ev) out_data <= rounded;
  end

  // R3: a held output does not move and blocks new input
  assert_hold_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  assert_no_accept_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R7: positive half or more rounds up; negative exact tie goes down
  assert_round_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev && !rnd_in[RND_W-1] && rnd_in[FRAC_W-1:0] >= HALF
       && rnd_in[RND_W-1:FRAC_W] != MAXPOS
    |=> out_data == $past(rnd_in[RND_W-1:FRAC_W]) + 1'b1);
  assert_neg_tie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev && rnd_in[RND_W-1] && rnd_in[FRAC_W-1:0] == HALF
    |=> out_data == $past(rnd_in[RND_W-1:FRAC_W]));

  // R8: the largest positive integer part never wraps
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev && rnd_in[RND_W-1:FRAC_W] == MAXPOS |=> out_data == MAXPOS);
endmodule

// File: tb/sim_cic_decim.sv
module sim_cic_decim;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, start, cfg_bypass, in_valid, in_ready, out_valid, out_ready;
  logic [2:0]  cfg_stages;
  logic [9:0]  cfg_rate;
  logic [5:0]  cfg_growth;
  logic [15:0] in_data, out_data;

  cic_decim u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_stages(cfg_stages),
    .cfg_rate(cfg_rate), .cfg_growth(cfg_growth), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  int    n_chk = 0, n_fail = 0;
  string tag;
  int    tol;

  // full-precision reference state
  logic signed [65:0] mi [5];
  logic signed [65:0] mc [5];
  logic signed [65:0] mdec;
  logic [15:0]        mout;
  bit                 mvalid, mrun;
  int                 mcnt, ne, re, ge;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int gcalc(input int n, input int rate);
    longint p = 1;
    int k = 0;
    for (int i = 0; i < n; i++) p = p * (rate + 1);
    while ((longint'(1) << k) < p) k++;
    return 50 - k;
  endfunction

  function automatic logic [15:0] fround(input logic signed [65:0] v);
    logic signed [65:0] ip, r;
    logic [49:0] fr, half;
    bit up;
    ip   = v >>> 50;
    fr   = v[49:0];
    half = 50'd1 << 49;
    up   = v[65] ? (fr > half) : (fr >= half);
    r    = ip + (up ? 66'sd1 : 66'sd0);
    if (r > 66'sd32767) r = 66'sd32767;
    return r[15:0];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 5; k++) begin mi[k] = '0; mc[k] = '0; end
    mdec = '0; mout = '0; mvalid = 0; mrun = 0; mcnt = 0;
  endtask

  task automatic model_accept(input logic [15:0] d, input bit ordy);
    logic signed [65:0] sx, c, dd;
    if (mcnt >= re) begin
      c = mdec;
      for (int k = 0; k < 5; k++) begin
        dd = c - ((k < ne) ? mc[k] : 66'sd0);
        mc[k] = c;
        c = dd;
      end
      mout = fround(c); mdec = mi[4]; mcnt = 0; mvalid = 1;
    end else begin
      mcnt++;
      if (ordy) mvalid = 0;
    end
    sx = 66'(signed'(d));
    sx = sx <<< ge;
    for (int k = 4; k >= 0; k--)
      mi[k] = ((k < ne) ? mi[k] : 66'sd0) + ((k == 0) ? sx : mi[k-1]);
  endtask

  // called at a falling edge; covers the next rising edge
  task automatic drive(input bit v, input logic [15:0] d, input bit ordy, input bit st);
    bit mrdy;
    check(out_valid === mvalid, tag, "out_valid", longint'(out_valid), longint'(mvalid));
    if (mvalid && out_valid) begin
      int a = int'($signed(out_data));
      int e = int'($signed(mout));
      check((a - e <= tol) && (e - a <= tol), tag, "out_data", a, e);
    end
    in_valid = v; in_data = d; out_ready = ordy; start = st;
    #1;
    mrdy = mrun && (!mvalid || ordy);
    check(in_ready === mrdy, tag, "in_ready", longint'(in_ready), longint'(mrdy));
    if (v && mrdy) model_accept(d, ordy);
    else if (ordy) mvalid = 0;
    if (st) mrun = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 0; start = 0; out_ready = 0; in_data = '0;
    repeat (2) @(negedge clk);
    check(out_valid === 1'b0, "R11", "out_valid in reset", longint'(out_valid), 0);
    check(out_data === 16'h0, "R11", "out_data in reset", longint'(out_data), 0);
    check(in_ready === 1'b0, "R1", "in_ready in reset", longint'(in_ready), 0);
    model_reset();
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic scn(input int stg, input int rate, input int grw, input bit byp,
                     input int nsamp, input bit dc, input int dcv, input int vp,
                     input int rp, input int tl, input string tg,
                     input bit chk_final, input int fexp);
    tag = tg; tol = tl;
    cfg_stages = 3'(stg); cfg_rate = 10'(rate); cfg_growth = 6'(grw); cfg_bypass = byp;
    ne = byp ? 0 : ((stg > 5) ? 5 : stg);
    re = byp ? 0 : rate;
    ge = byp ? 50 : ((grw > 50) ? 50 : grw);
    do_reset();
    drive(1, 16'h1234, 1, 0);   // not started yet: must not be taken (R1)
    drive(0, '0, 1, 1);
    for (int i = 0; i < nsamp; i++) begin
      bit v = (int'($urandom % 100) < vp);
      bit r = (int'($urandom % 100) < rp);
      int x = dc ? dcv : (int'($urandom % 60001) - 30000);
      drive(v, 16'(x), r, 0);
    end
    repeat (3) drive(0, '0, 1, 0);
    if (chk_final) begin
      int a = int'($signed(out_data));
      check((a - fexp <= tl) && (fexp - a <= tl), tg, "settled value", a, fexp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    cfg_stages = 0; cfg_rate = 0; cfg_growth = 0; cfg_bypass = 0;
    rst_n = 0; start = 0; in_valid = 0; out_ready = 0; in_data = 0;
    @(negedge clk);

    // R6: bypass ignores stages/rate/growth and delays by six accepts
    scn(3, 9, 10, 1, 300, 0, 0, 80, 70, 0, "R6", 0, 0);
    // R2: full-rate handshakes, one output per five accepts
    scn(1, 4, gcalc(1, 4), 0, 200, 0, 0, 100, 100, 1, "R2", 0, 0);
    // R10: DC with power-of-two gain settles to the input
    scn(3, 7, gcalc(3, 7), 0, 400, 1, 12345, 90, 90, 1, "R10", 1, 12345);
    scn(5, 3, gcalc(5, 3), 0, 400, 1, -23456, 90, 90, 1, "R10", 1, -23456);
    // R7: exact ties +1.5 / -1.5 / -32767.5
    scn(1, 1, 48, 0, 60, 1, 3, 100, 100, 0, "R7", 1, 2);
    scn(1, 1, 48, 0, 60, 1, -3, 100, 100, 0, "R7", 1, -2);
    scn(1, 2, 49, 0, 60, 1, -21845, 100, 100, 0, "R7", 1, -32768);
    // R8: +32767.5 saturates instead of wrapping
    scn(1, 2, 49, 0, 60, 1, 21845, 100, 100, 0, "R8", 1, 32767);
    // R4: stage count 7 acts as 5
    scn(7, 3, gcalc(5, 3), 0, 300, 0, 0, 85, 85, 1, "R4", 0, 0);
    // R5: growth 63 acts as 50 (unity gain, exact)
    scn(1, 0, 63, 0, 200, 0, 0, 85, 85, 0, "R5", 0, 0);
    // R12: sparse input, irregular output acceptance
    scn(2, 5, gcalc(2, 5), 0, 600, 0, 0, 30, 40, 1, "R12", 0, 0);
    // R3: heavy output back-pressure
    scn(4, 1, gcalc(4, 1), 0, 500, 0, 0, 100, 20, 1, "R3", 0, 0);
    // R9: random configurations against the full-precision reference
    for (int t = 0; t < 6; t++) begin
      int n = 1 + int'($urandom % 5);
      int r = int'($urandom % 21);
      scn(n, r, gcalc(n, r), 0, 500, 0, 0, 80, 80, 1, "R9", 0, 0);
    end
    scn(5, 1023, gcalc(5, 1023), 0, 7000, 0, 0, 95, 90, 1, "R9", 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule